// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the serial command front end of a small electrically erasable memory, built as synchronous logic on one system clock. The serial lines (select, serial clock, data in) arrive as plain inputs. The block finds serial clock rising edges by comparing each sample with the one before it. A command frame opens with a start bit. The opcode, address and write data follow, most significant bit first. A frame runs only after its last required bit has arrived. Read data and ready/busy status leave on a data-out pin that has a separate output-enable, so the pad can be tri-stated.

The storage is a register array of bytes. A strap input sets the word size to 16 bits or to 8 bits. In 16-bit mode word `n` is bytes `2n` (high) and `2n+1` (low), so the two views of the array agree. Programming commands update the array at once and then hold a busy period of `PROG_CYCLES` system clocks. During that period data-out reports busy. A sticky enable flag and an active-low protect input both gate every command that changes the array. The serial pins carry no valid/ready handshake. The host paces every bit with the serial clock and no back-pressure exists.

Top module: `sep_eeprom`

## Requirements
- R1: After reset, `dout_oe` is low, the enable flag is clear and every byte of the array reads as 0xFF. A write sent before any enable command leaves the array unchanged and starts no busy period.
- R2: A frame starts only on a serial clock rise at which `sel` and `sdi` are both high. Rises with `sdi` low before that are ignored.
- R3: The frame is: start bit, 2-bit opcode, address, then data for writes only, each field MSB first. Opcode 10 is read, 01 is write, 11 is erase. Opcode 00 uses the top two address bits: 00 lock, 01 fill-all, 10 erase-all, 11 unlock.
- R4: A frame that `sel` cuts short before its last bit has no effect.
- R5: A read drives a 0 (the dummy bit) on the rise that clocks in the last address bit. Each later rise drives the next data bit, MSB first. After the last bit of a word, the read moves on to the next address, which wraps at the end of the array.
- R6: With `org16` high, words are 16 bits and the address is `ADDR_BITS` wide. With `org16` low, words are 8 bits and the address is `ADDR_BITS+1` wide. 16-bit word n is bytes 2n (high) and 2n+1 (low).
- R7: When enabled and unprotected, write stores the data word and erase sets the word to all ones.
- R8: When enabled and unprotected, fill-all writes the data word into every word, and erase-all sets every bit to one.
- R9: Unlock sets the sticky enable flag and lock clears it. While the flag is clear, write, erase, fill-all and erase-all have no effect.
- R10: After a programming command starts, data-out is driven low for `PROG_CYCLES` clocks while `sel` is high, then driven high. No new frame starts while busy.
- R11: While `prot_n` is low, write, erase, fill-all and erase-all have no effect and start no busy period.
- R12: `dout_oe` is low whenever `sel` is low, and also when neither a read nor a status report is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org16 | input | 1 | Word size strap: 1 = 16-bit, 0 = 8-bit |
| prot_n | input | 1 | Low blocks all array-changing commands |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bench sends several kinds of frame that should be refused: frames led by zero bits, frames cut off one bit early, writes while locked and writes while protected. A design that counted the leading zeros or ran a partial frame would corrupt a word, and a later read would show it. Reads are checked for the dummy zero and for the wrap from the last word back to word 0, where an off-by-one gives shifted or wrong data. The busy period is sampled just inside and just past `PROG_CYCLES`, and a frame sent during busy must not run. Bytes written in 8-bit mode are read back as 16-bit words, which catches a swapped byte order.

// File: rtl/sep_pkg.sv
package sep_pkg;
  typedef enum logic [2:0] {
    CMD_RD, CMD_WR, CMD_ERS, CMD_LOCK, CMD_FILL, CMD_BLANK, CMD_UNLOCK
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SHIFT, ST_READ, ST_HOLD
  } rx_st_e;
endpackage

// File: rtl/sep_prog_timer.sv
module sep_prog_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R10: a launch always opens a busy period
  a_r10_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/sep_cell_array.sv
module sep_cell_array #(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 org16,
  input  logic                 wr_one,
  input  logic                 wr_all,
  input  logic [ADDR_BITS:0]   waddr,
  input  logic [15:0]          wdata,
  input  logic [ADDR_BITS:0]   rd_ptr,
  output logic [15:0]          rd_word
);
  localparam int AWM    = ADDR_BITS + 1;
  localparam int NBYTES = 1 << AWM;

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < NBYTES; i++) mem[i[AWM-1:0]] <= 8'hFF;
    end else if (wr_all) begin
      for (int unsigned i = 0; i < NBYTES; i++)
        mem[i[AWM-1:0]] <= (org16 && !i[0]) ? wdata[15:8] : wdata[7:0];
    end else if (wr_one) begin
      if (org16) begin
        mem[{waddr[AWM-2:0], 1'b0}] <= wdata[15:8];
        mem[{waddr[AWM-2:0], 1'b1}] <= wdata[7:0];
      end else begin
        mem[waddr] <= wdata[7:0];
      end
    end
  end

  always_comb begin
    if (org16) rd_word = {mem[{rd_ptr[AWM-2:0], 1'b0}], mem[{rd_ptr[AWM-2:0], 1'b1}]};
    else       rd_word = {8'h00, mem[rd_ptr]};
  end

  // R7: a single byte write lands at its address
  a_r7_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one && !wr_all && !org16) |=> mem[$past(waddr)] == $past(wdata[7:0]));
endmodule

// File: rtl/sep_frame_rx.sv
module sep_frame_rx
  import sep_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               org16,
  input  logic               busy,
  input  logic [15:0]        rd_word,
  output logic               cmd_valid,
  output cmd_e               cmd,
  output logic [ADDR_BITS:0] cmd_addr,
  output logic [15:0]        cmd_data,
  output logic [ADDR_BITS:0] rd_ptr,
  output logic               rd_active,
  output logic               rd_bit
);
  localparam int AWM = ADDR_BITS + 1;
  localparam int CW  = $clog2(2 + AWM + 16 + 1);

  rx_st_e         state;
  logic           sclk_q;
  logic           rise;
  logic [CW-1:0]  cnt;
  logic [1:0]     op;
  logic [AWM-1:0] addr, addr_n, ptr_inc, ptr_nx;
  logic [15:0]    data, data_n;
  logic [1:0]     sub;
  logic [3:0]     bit_i, top_bit;
  logic [CW-1:0]  aw_c, last_addr, last_data;

  always_comb begin
    rise      = sclk && !sclk_q;
    addr_n    = {addr[AWM-2:0], sdi};
    data_n    = {data[14:0], sdi};
    sub       = org16 ? addr_n[ADDR_BITS-1:ADDR_BITS-2] : addr_n[AWM-1:AWM-2];
    aw_c      = org16 ? CW'(ADDR_BITS) : CW'(AWM);
    top_bit   = org16 ? 4'd15 : 4'd7;
    last_addr = aw_c + CW'(1);
    last_data = aw_c + (org16 ? CW'(16) : CW'(8)) + CW'(1);
    ptr_inc   = rd_ptr + 1'b1;
    ptr_nx    = org16 ? {1'b0, ptr_inc[AWM-2:0]} : ptr_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; sclk_q <= 1'b0; cnt <= '0; op <= '0; addr <= '0;
      data <= '0; bit_i <= '0; rd_ptr <= '0; rd_bit <= 1'b0;
      cmd_valid <= 1'b0; cmd <= CMD_RD; cmd_addr <= '0; cmd_data <= '0;
    end else begin
      sclk_q    <= sclk;
      cmd_valid <= 1'b0;
      if (!sel) begin
        state <= ST_IDLE;
      end else if (rise) begin
        case (state)
          ST_IDLE: if (sdi && !busy) begin
            state <= ST_SHIFT; cnt <= '0; op <= '0; addr <= '0; data <= '0;
          end
          ST_SHIFT: begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(2)) begin
              op <= {op[0], sdi};
            end else if (cnt <= last_addr) begin
              addr <= addr_n;
              if (cnt == last_addr) begin
                cmd_addr <= addr_n;
                case (op)
                  2'b10: begin
                    state <= ST_READ; rd_ptr <= addr_n; bit_i <= top_bit; rd_bit <= 1'b0;
                  end
                  2'b01: ;
                  2'b11: begin cmd_valid <= 1'b1; cmd <= CMD_ERS; state <= ST_HOLD; end
                  default: begin
                    case (sub)
                      2'b00: begin cmd_valid <= 1'b1; cmd <= CMD_LOCK; state <= ST_HOLD; end
                      2'b10: begin cmd_valid <= 1'b1; cmd <= CMD_BLANK; state <= ST_HOLD; end
                      2'b11: begin cmd_valid <= 1'b1; cmd <= CMD_UNLOCK; state <= ST_HOLD; end
                      default: ;
                    endcase
                  end
                endcase
              end
            end else begin
              data <= data_n;
              if (cnt == last_data) begin
                cmd_valid <= 1'b1;
                cmd_data  <= data_n;
                cmd       <= (op == 2'b01) ? CMD_WR : CMD_FILL;
                state     <= ST_HOLD;
              end
            end
          end
          ST_READ: begin
            rd_bit <= rd_word[bit_i];
            if (bit_i == 4'd0) begin
              bit_i  <= top_bit;
              rd_ptr <= ptr_nx;
            end else begin
              bit_i <= bit_i - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active = (state == ST_READ);

  // R10: no frame opens while a programming cycle runs
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == ST_IDLE) |=> state == ST_IDLE);
  // R5: the first bit of a read is the dummy zero
  a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> !rd_bit);
endmodule

// File: rtl/sep_eeprom.sv
module sep_eeprom
  import sep_pkg::*;
#(
  parameter int ADDR_BITS   = 6,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org16,
  input  logic prot_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic dout,
  output logic dout_oe
);
  logic               cmd_valid, busy, rd_active, rd_bit;
  cmd_e               cmd;
  logic [ADDR_BITS:0] cmd_addr, rd_ptr;
  logic [15:0]        cmd_data, rd_word, wdata;
  logic               en_flag, stat_flag, is_prog, launch, wr_one, wr_all, status_oe;

  sep_frame_rx #(.ADDR_BITS(ADDR_BITS)) u_rx (
    .clk, .rst_n, .sel, .sclk, .sdi, .org16, .busy, .rd_word,
    .cmd_valid, .cmd, .cmd_addr, .cmd_data, .rd_ptr, .rd_active, .rd_bit
  );

  sep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk, .rst_n, .start(launch), .busy
  );

  sep_cell_array #(.ADDR_BITS(ADDR_BITS)) u_array (
    .clk, .rst_n, .org16, .wr_one, .wr_all, .waddr(cmd_addr), .wdata,
    .rd_ptr, .rd_word
  );

  always_comb begin
    is_prog = cmd_valid &&
              (cmd == CMD_WR || cmd == CMD_ERS || cmd == CMD_FILL || cmd == CMD_BLANK);
    launch  = is_prog && en_flag && prot_n && !busy;
    wr_one  = launch && (cmd == CMD_WR || cmd == CMD_ERS);
    wr_all  = launch && (cmd == CMD_FILL || cmd == CMD_BLANK);
    wdata   = (cmd == CMD_ERS || cmd == CMD_BLANK) ? 16'hFFFF : cmd_data;
    status_oe = sel && (busy || stat_flag);
    dout_oe   = sel && (rd_active || status_oe);
    dout      = rd_active ? rd_bit : (status_oe ? !busy : 1'b0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_flag   <= 1'b0;
      stat_flag <= 1'b0;
    end else begin
      if (cmd_valid && cmd == CMD_UNLOCK) en_flag <= 1'b1;
      else if (cmd_valid && cmd == CMD_LOCK) en_flag <= 1'b0;
      if (!sel) stat_flag <= 1'b0;
      else if (launch) stat_flag <= 1'b1;
    end
  end

  // R9, R11: a busy period only follows an enabled, unprotected command
  a_r11_gate_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(en_flag) && $past(prot_n)));
  // R9: lock clears the enable flag
  a_r9_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_LOCK) |=> !en_flag);
  // R10: status reads low while busy
  a_r10_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && busy) |-> !dout);
endmodule

// File: tb/test_sep_eeprom.sv
module test_sep_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int AB = 6;
  localparam int P  = 64;
  localparam int NB = 1 << (AB + 1);

  logic clk = 1'b0, rst_n = 1'b0, org16 = 1'b1, prot_n = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic dout, dout_oe;
  int checks = 0, errors = 0;
  logic [7:0] mdl [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sep_eeprom #(.ADDR_BITS(AB), .PROG_CYCLES(P)) i_sep_eeprom (
    .clk, .rst_n, .org16, .prot_n, .sel, .sclk, .sdi, .dout, .dout_oe
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int awid(logic o);
    return o ? AB : AB + 1;
  endfunction

  function automatic logic [15:0] mword(logic o, int a);
    if (o) return {mdl[2 * a], mdl[2 * a + 1]};
    return {8'h00, mdl[a]};
  endfunction

  task automatic mwrite(logic o, int a, logic [15:0] d);
    if (o) begin mdl[2 * a] = d[15:8]; mdl[2 * a + 1] = d[7:0]; end
    else mdl[a] = d[7:0];
  endtask

  task automatic sbit(logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_on;
    @(negedge clk); sel = 1'b1; sclk = 1'b0; sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off;
    @(negedge clk); sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // full programming frame; checks whether a busy period started
  task automatic prog(string tag, logic [1:0] op, int a, logic [15:0] d, bit has_d, bit expect_run);
    cs_on;
    sbit(1'b1);
    send(op, 2);
    send(a, awid(org16));
    if (has_d) send(d, org16 ? 16 : 8);
    check(tag, {dout_oe, dout}, expect_run ? 2'b10 : 2'b00);
    cs_off;
    repeat (P + 6) @(negedge clk);
  endtask

  task automatic rd_burst(string tag, int a, int n);
    int aw = awid(org16);
    int cur = a;
    cs_on;
    sbit(1'b1);
    send(2'b10, 2);
    send(a, aw);
    check({tag, " dummy"}, {dout_oe, dout}, 2'b10);
    for (int w = 0; w < n; w++) begin
      logic [15:0] got = '0;
      for (int b = 0; b < (org16 ? 16 : 8); b++) begin
        sbit(1'b0);
        got = {got[14:0], dout};
      end
      check(tag, got, mword(org16, cur));
      cur = (cur + 1) % (1 << aw);
    end
    cs_off;
    check({tag, " hiz"}, dout_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R12 reset oe", dout_oe, 1'b0);
    rd_burst("R1 blank", 0, 1);

    // R1: write before unlock is refused
    prog("R1 locked write", 2'b01, 3, 16'h1234, 1'b1, 1'b0);
    rd_burst("R1 unchanged", 3, 1);

    // R2: leading zero clocks, then unlock frame
    cs_on;
    send(3'b000, 3);
    sbit(1'b1); send(2'b00, 2); send(6'b110000, AB);
    cs_off;

    // R7 R10: write with busy timing
    cs_on;
    sbit(1'b1); send(2'b01, 2); send(3, AB); send(16'hA5C3, 16);
    mwrite(1'b1, 3, 16'hA5C3);
    check("R10 busy low", {dout_oe, dout}, 2'b10);
    repeat (P - 4) @(negedge clk);
    check("R10 still busy", {dout_oe, dout}, 2'b10);
    repeat (6) @(negedge clk);
    check("R10 ready high", {dout_oe, dout}, 2'b11);
    cs_off;
    check("R12 hiz after sel", dout_oe, 1'b0);
    rd_burst("R2 R7 write", 3, 1);

    // R4: truncated frame
    cs_on;
    sbit(1'b1); send(2'b01, 2); send(5, AB); send(16'h00F0 >> 1, 15);
    cs_off;
    cs_on;
    check("R4 no busy", dout_oe, 1'b0);
    cs_off;
    rd_burst("R4 unchanged", 5, 1);

    // R6: byte view of the same array
    org16 = 1'b0;
    rd_burst("R6 bytes", 6, 2);
    prog("R6 byte write", 2'b01, 9, 16'h005A, 1'b1, 1'b1);
    mwrite(1'b0, 9, 16'h005A);
    org16 = 1'b1;
    rd_burst("R6 word view", 4, 1);
    check("R6 order", mword(1'b1, 4), 16'hFF5A);

    // R5: sequential read wraps
    prog("R5 setup", 2'b01, 63, 16'hBEEF, 1'b1, 1'b1);
    mwrite(1'b1, 63, 16'hBEEF);
    rd_burst("R5 wrap", 62, 3);

    // R7: erase
    prog("R7 erase", 2'b11, 3, 16'h0, 1'b0, 1'b1);
    mwrite(1'b1, 3, 16'hFFFF);
    rd_burst("R7 erased", 3, 1);

    // R11: protect
    prot_n = 1'b0;
    prog("R11 protected", 2'b01, 7, 16'h7777, 1'b1, 1'b0);
    prot_n = 1'b1;
    rd_burst("R11 unchanged", 7, 1);

    // R9: lock then refused
    prog("R9 lock", 2'b00, 6'b000000, 16'h0, 1'b0, 1'b0);
    prog("R9 refused", 2'b01, 8, 16'h8888, 1'b1, 1'b0);
    rd_burst("R9 unchanged", 8, 1);
    prog("R9 unlock", 2'b00, 6'b110000, 16'h0, 1'b0, 1'b0);

    // R3 R8: fill-all and erase-all
    prog("R8 fill", 2'b00, 6'b010000, 16'h1357, 1'b1, 1'b1);
    for (int i = 0; i < 64; i++) mwrite(1'b1, i, 16'h1357);
    rd_burst("R3 R8 filled", 0, 2);
    rd_burst("R8 filled end", 63, 1);
    prog("R8 blank", 2'b00, 6'b100000, 16'h0, 1'b0, 1'b1);
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    rd_burst("R8 blanked", 20, 2);

    // R10: frame during busy ignored
    cs_on;
    sbit(1'b1); send(2'b01, 2); send(10, AB); send(16'h2468, 16);
    mwrite(1'b1, 10, 16'h2468);
    cs_off;
    cs_on;
    check("R10 busy reselect", {dout_oe, dout}, 2'b10);
    sbit(1'b1); send(2'b11, 2); send(10, AB);
    cs_off;
    repeat (P + 6) @(negedge clk);
    rd_burst("R10 ignored", 10, 1);

    // R6 R7: random writes and bursts in both word sizes
    for (int k = 0; k < 24; k++) begin
      int a;
      logic [15:0] d;
      org16 = 1'($urandom_range(0, 1));
      a = int'($urandom_range(0, (1 << awid(org16)) - 1));
      d = 16'($urandom);
      prog("R7 rand write", 2'b01, a, d, 1'b1, 1'b1);
      mwrite(org16, a, d);
      if (k % 4 == 3) rd_burst("R5 R6 rand read", a, 3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule